// File: doc/BRIEF.md
# Oscillator Fine-Code Compensation Search Controller

This block finds, at run time, how far the fine-tuning code must be raised when a coarse/fine digitally controlled oscillator steps up one coarse band, so that its frequency keeps rising across the step. After reset it runs a search on its own. The main oscillator gets a fixed reference code: coarse band K with the fine field at full scale. A replica oscillator gets band K+1, with a fine value that starts at zero and climbs by one per trial.

For each trial the block releases a shared oscillator-stop line. It lets both clocks run for a programmable number of cycles, then reads an external lead/lag bit through a synchroniser, and then stops the clocks again. The first fine value at which the replica leads is kept as the compensation offset. If no value leads, the search ends at full scale and raises a sticky error flag.

When the search is over, the block passes the incoming control code through to the main oscillator. The offset is added to the fine field, and the sum is clamped at full scale. It also reports each change in the coarse field of the incoming code. A start pulse runs the search again without a reset.

Top module: `dco_cal_ctrl`

## Requirements
- R1: While reset is asserted, done_o=0, error_o=0, cal_x_o=0 and dco_dis_o=1. When reset is released, the search starts with no other input.
- R2: A control code is {coarse, fine}, with the coarse field in the upper COARSE_W bits and the fine field in the lower FINE_W bits. While done_o=0, main_code_o is {CAL_COARSE, all-ones fine}.
- R3: rep_code_o has coarse field CAL_COARSE+1. Its fine field is 0 when a search begins and rises by exactly one for each trial that does not lead.
- R4: In a trial, dco_dis_o is low for max(settle_cycles_i,1)+2 cycles and high for 2 cycles between trials. rep_code_o changes only while dco_dis_o is high.
- R5: pd_lead_i=1 means the replica leads. It is sampled through a two-flop synchroniser at the end of each trial. The first leading trial stores its fine value in cal_x_o and raises done_o.
- R6: If the trial at the all-ones fine value does not lead, cal_x_o becomes all ones and error_o is set. error_o stays set through later searches until reset.
- R7: With done_o=1, main_code_o takes, one cycle after ctrl_code_i, the same coarse field and the fine field min(fine+cal_x_o, 2^FINE_W-1).
- R8: With done_o=1, coarse_chg_o is high for one cycle, one cycle after the coarse field of ctrl_code_i differs from its value in the previous cycle. A change in the fine field alone does not raise it.
- R9: A start_i pulse while done_o=1 clears done_o on the next cycle and restarts the search from fine value 0. start_i is ignored during a search.
- R10: While done_o=1, dco_dis_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Rerun the search (used only when done) |
| settle_cycles_i | input | WAIT_W | Cycles the clocks run per trial (0 acts as 1) |
| pd_lead_i | input | 1 | Asynchronous phase detector result, 1 = replica leads |
| ctrl_code_i | input | COARSE_W+FINE_W | Incoming oscillator control code |
| main_code_o | output | COARSE_W+FINE_W | Code to the main oscillator |
| rep_code_o | output | COARSE_W+FINE_W | Code to the replica oscillator |
| dco_dis_o | output | 1 | Stops both oscillators when high |
| done_o | output | 1 | Search finished, normal mode |
| error_o | output | 1 | Sticky: no fine value led |
| cal_x_o | output | FINE_W | Stored compensation offset |
| coarse_chg_o | output | 1 | One-cycle flag for a coarse change |

## Verification
The bench models the detector so that it leads at a chosen fine threshold. It covers a threshold of zero, a middle value and a threshold that is never reached. A design with an off-by-one in the stored value, or one that stops one trial early, shows a wrong offset or a wrong trial count. The bench also watches every code change against the stop line and checks the low time of each trial, which exposes a code applied while the clocks run or a miscounted settle window. Fine sums above full scale must clamp rather than wrap. The error flag must survive a later successful search. A second start pulse during a search must not add a trial.

// File: rtl/dco_cal_pkg.sv
package dco_cal_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_RUN,
    ST_SYNC,
    ST_EVAL,
    ST_DONE
  } cal_st_e;
endpackage

// File: rtl/dco_cal_sync.sv
module dco_cal_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff[i] <= 1'b0;
      else if (i == 0) ff[i] <= d_i;
      else ff[i] <= ff[(i == 0) ? 0 : i-1];
    end
  end

  assign q_o = ff[STAGES-1];
endmodule

// File: rtl/dco_cal_seq.sv
module dco_cal_seq
  import dco_cal_pkg::*;
#(
  parameter int FINE_W      = 5,
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WAIT_W-1:0] settle_i,
  input  logic              lead_i,
  output logic [FINE_W-1:0] fine_o,
  output logic              dis_o,
  output logic              done_o,
  output logic              error_o,
  output logic [FINE_W-1:0] cal_x_o
);
  localparam logic [FINE_W-1:0] FINE_MAX  = '1;
  localparam logic [WAIT_W-1:0] SYNC_LAST = WAIT_W'(SYNC_STAGES - 1);

  cal_st_e           st;
  logic [WAIT_W-1:0] cnt;
  logic [WAIT_W-1:0] run_last;

  assign run_last = (settle_i == '0) ? '0 : settle_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st      <= ST_HOLD;
      cnt     <= '0;
      fine_o  <= '0;
      done_o  <= 1'b0;
      error_o <= 1'b0;
      cal_x_o <= '0;
    end else begin
      unique case (st)
        ST_HOLD: begin
          cnt <= '0;
          st  <= ST_RUN;
        end
        ST_RUN: begin
          if (cnt == run_last) begin
            cnt <= '0;
            st  <= ST_SYNC;
          end else cnt <= cnt + 1'b1;
        end
        ST_SYNC: begin
          // let the detector result cross the synchroniser
          if (cnt == SYNC_LAST) begin
            cnt <= '0;
            st  <= ST_EVAL;
          end else cnt <= cnt + 1'b1;
        end
        ST_EVAL: begin
          if (lead_i) begin
            cal_x_o <= fine_o;
            done_o  <= 1'b1;
            st      <= ST_DONE;
          end else if (fine_o == FINE_MAX) begin
            cal_x_o <= FINE_MAX;
            error_o <= 1'b1;
            done_o  <= 1'b1;
            st      <= ST_DONE;
          end else begin
            fine_o <= fine_o + 1'b1;
            st     <= ST_HOLD;
          end
        end
        ST_DONE: begin
          if (start_i) begin
            fine_o <= '0;
            done_o <= 1'b0;
            st     <= ST_HOLD;
          end
        end
        default: st <= ST_HOLD;
      endcase
    end
  end

  assign dis_o = (st == ST_HOLD) || (st == ST_EVAL);
endmodule

// File: rtl/dco_cal_map.sv
module dco_cal_map #(
  parameter int COARSE_W = 6,
  parameter int FINE_W   = 5
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       done_i,
  input  logic [COARSE_W+FINE_W-1:0] code_i,
  input  logic [COARSE_W+FINE_W-1:0] ref_code_i,
  input  logic [FINE_W-1:0]          cal_x_i,
  output logic [COARSE_W+FINE_W-1:0] code_o,
  output logic                       chg_o
);
  localparam int CW = COARSE_W + FINE_W;

  logic [COARSE_W-1:0] coarse_in, coarse_prev;
  logic [FINE_W:0]     sum;
  logic [FINE_W-1:0]   fine_sat;

  assign coarse_in = code_i[CW-1:FINE_W];
  assign sum       = {1'b0, code_i[FINE_W-1:0]} + {1'b0, cal_x_i};
  assign fine_sat  = sum[FINE_W] ? '1 : sum[FINE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_o      <= ref_code_i;
      chg_o       <= 1'b0;
      coarse_prev <= '0;
    end else begin
      coarse_prev <= coarse_in;
      chg_o       <= done_i && (coarse_in != coarse_prev);
      code_o      <= done_i ? {coarse_in, fine_sat} : ref_code_i;
    end
  end
endmodule

// File: rtl/dco_cal_ctrl.sv
module dco_cal_ctrl #(
  parameter int COARSE_W    = 6,
  parameter int FINE_W      = 5,
  parameter int WAIT_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int CAL_COARSE  = 31
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       start_i,
  input  logic [WAIT_W-1:0]          settle_cycles_i,
  input  logic                       pd_lead_i,
  input  logic [COARSE_W+FINE_W-1:0] ctrl_code_i,
  output logic [COARSE_W+FINE_W-1:0] main_code_o,
  output logic [COARSE_W+FINE_W-1:0] rep_code_o,
  output logic                       dco_dis_o,
  output logic                       done_o,
  output logic                       error_o,
  output logic [FINE_W-1:0]          cal_x_o,
  output logic                       coarse_chg_o
);
  localparam int CW = COARSE_W + FINE_W;
  localparam logic [COARSE_W-1:0] REF_COARSE = COARSE_W'(CAL_COARSE);
  localparam logic [COARSE_W-1:0] REP_COARSE = COARSE_W'(CAL_COARSE + 1);
  localparam logic [CW-1:0]       REF_CODE   = {REF_COARSE, {FINE_W{1'b1}}};

  logic              lead_sync;
  logic [FINE_W-1:0] rep_fine;

  dco_cal_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pd_lead_i),
    .q_o   (lead_sync)
  );

  dco_cal_seq #(
    .FINE_W     (FINE_W),
    .WAIT_W     (WAIT_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .settle_i(settle_cycles_i),
    .lead_i  (lead_sync),
    .fine_o  (rep_fine),
    .dis_o   (dco_dis_o),
    .done_o  (done_o),
    .error_o (error_o),
    .cal_x_o (cal_x_o)
  );

  dco_cal_map #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_map (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .done_i    (done_o),
    .code_i    (ctrl_code_i),
    .ref_code_i(REF_CODE),
    .cal_x_i   (cal_x_o),
    .code_o    (main_code_o),
    .chg_o     (coarse_chg_o)
  );

  assign rep_code_o = {REP_COARSE, rep_fine};
endmodule

// File: rtl/dco_cal_ctrl_chk.sv
module dco_cal_ctrl_chk #(
  parameter int COARSE_W   = 6,
  parameter int FINE_W     = 5,
  parameter int CAL_COARSE = 31
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [COARSE_W+FINE_W-1:0] ctrl_code_i,
  input logic [COARSE_W+FINE_W-1:0] main_code_o,
  input logic [COARSE_W+FINE_W-1:0] rep_code_o,
  input logic                       dco_dis_o,
  input logic                       done_o,
  input logic                       error_o,
  input logic [FINE_W-1:0]          cal_x_o,
  input logic                       coarse_chg_o
);
  localparam int CW = COARSE_W + FINE_W;
  localparam logic [CW-1:0] REF_CODE = {COARSE_W'(CAL_COARSE), {FINE_W{1'b1}}};

  logic [FINE_W-1:0] rep_fine;
  assign rep_fine = rep_code_o[FINE_W-1:0];

  AST_CODE_WHILE_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rep_code_o) |-> dco_dis_o); // R4
  AST_FINE_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(rep_fine) |-> (rep_fine == FINE_W'($past(rep_fine) + 1'b1)) || (rep_fine == '0)); // R3
  AST_REF_IN_SEARCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !$fell(done_o)) |-> main_code_o == REF_CODE); // R2
  AST_RUN_IN_NORMAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !dco_dis_o); // R10
  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(error_o) |-> error_o); // R6
  AST_ERR_FULL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(error_o) |-> cal_x_o == '1); // R6
  AST_CHG_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coarse_chg_o |-> $past(done_o)); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(done_o) |-> (main_code_o[FINE_W-1:0] >= $past(ctrl_code_i[FINE_W-1:0]))
      && (main_code_o[CW-1:FINE_W] == $past(ctrl_code_i[CW-1:FINE_W]))); // R7
endmodule

bind dco_cal_ctrl dco_cal_ctrl_chk #(
  .COARSE_W  (COARSE_W),
  .FINE_W    (FINE_W),
  .CAL_COARSE(CAL_COARSE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ctrl_code_i (ctrl_code_i),
  .main_code_o (main_code_o),
  .rep_code_o  (rep_code_o),
  .dco_dis_o   (dco_dis_o),
  .done_o      (done_o),
  .error_o     (error_o),
  .cal_x_o     (cal_x_o),
  .coarse_chg_o(coarse_chg_o)
);

// File: tb/dco_cal_ctrl_tb.sv
module dco_cal_ctrl_tb;
  localparam int MW = 6;
  localparam int NW = 5;
  localparam int WW = 8;
  localparam int K  = 31;
  localparam int CW = MW + NW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [WW-1:0] settle = 8'd3;
  logic          pd_lead;
  logic [CW-1:0] ctrl = '0;
  logic [CW-1:0] main_code, rep_code;
  logic          dis, done, err, chg;
  logic [NW-1:0] cal_x;

  int thr = 5;
  int n_chk = 0, n_err = 0;
  int windows = 0, cur_len = 0, last_len = 0, viol = 0, ref_bad = 0, max_fine = 0;
  logic          in_win = 1'b0, p_dis = 1'b1, p_done = 1'b0;
  logic [CW-1:0] p_rep = '0;

  always #10 clk = ~clk;

  // behavioural detector: replica leads once its fine code reaches thr
  assign pd_lead = (int'(rep_code[NW-1:0]) >= thr);

  dco_cal_ctrl #(.COARSE_W(MW), .FINE_W(NW), .WAIT_W(WW), .CAL_COARSE(K)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .settle_cycles_i(settle),
    .pd_lead_i(pd_lead), .ctrl_code_i(ctrl), .main_code_o(main_code),
    .rep_code_o(rep_code), .dco_dis_o(dis), .done_o(done), .error_o(err),
    .cal_x_o(cal_x), .coarse_chg_o(chg)
  );

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clear_mon();
    windows = 0; cur_len = 0; last_len = 0; viol = 0; ref_bad = 0; max_fine = 0;
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      in_win = 1'b0; p_dis = 1'b1; p_done = 1'b0; p_rep = rep_code;
    end else begin
      if (!done) begin
        if (p_dis && !dis) begin windows++; cur_len = 1; in_win = 1'b1; end
        else if (!dis && in_win) cur_len++;
        else if (dis && in_win) begin last_len = cur_len; in_win = 1'b0; end
        if (!p_done && main_code != {MW'(K), {NW{1'b1}}}) ref_bad++;
        if (int'(rep_code[NW-1:0]) > max_fine) max_fine = int'(rep_code[NW-1:0]);
      end else if (in_win) begin
        last_len = cur_len; in_win = 1'b0;
      end
      if (rep_code != p_rep && !dis) viol++;
      p_dis = dis; p_done = done; p_rep = rep_code;
    end
  end

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin @(negedge clk); n++; end
    check(done, req, "search completes", int'(done), 1);
  endtask

  task automatic pulse_start();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; thr = 5; settle = 8'd3;
    repeat (3) @(negedge clk);
    check(!done && !err && cal_x == 0, "R1", "done/error/cal_x in reset", int'({done, err}), 0);
    check(dis, "R1", "stop line in reset", int'(dis), 1);
    check(main_code == {MW'(K), {NW{1'b1}}}, "R2", "main reference code", int'(main_code), (K << NW) | 31);
    check(rep_code == {MW'(K + 1), NW'(0)}, "R3", "replica start code", int'(rep_code), (K + 1) << NW);
    clear_mon();
    rst_n = 1'b1;
  endtask

  task automatic t_mid_search();
    wait_done("R5");
    check(cal_x == 5, "R5", "offset at first lead", int'(cal_x), 5);
    check(!err, "R6", "no error on lead", int'(err), 0);
    check(windows == 6, "R3", "trials before lead", windows, 6);
    check(max_fine == 5, "R3", "highest replica fine", max_fine, 5);
    check(last_len == 5, "R4", "run window length", last_len, 5);
    check(viol == 0, "R4", "code changes while running", viol, 0);
    check(ref_bad == 0, "R2", "main code off reference", ref_bad, 0);
    @(negedge clk);
    check(!dis, "R10", "oscillators run when done", int'(dis), 0);
  endtask

  task automatic t_normal();
    int ef;
    @(negedge clk) ctrl = {6'd10, 5'd3};
    @(negedge clk);
    check(main_code == {6'd10, 5'd8}, "R7", "offset added", int'(main_code), (10 << NW) | 8);
    ctrl = {6'd10, 5'd30};
    @(negedge clk);
    ef = (30 + int'(cal_x) > 31) ? 31 : 30 + int'(cal_x);
    check(int'(main_code[NW-1:0]) == ef, "R7", "fine clamps at full scale", int'(main_code[NW-1:0]), ef);
    ctrl = {6'd63, 5'd0};
    @(negedge clk);
    check(main_code[CW-1:NW] == 6'd63, "R7", "coarse passes through", int'(main_code[CW-1:NW]), 63);
    check(chg, "R8", "coarse change flagged", int'(chg), 1);
    @(negedge clk);
    check(!chg, "R8", "flag lasts one cycle", int'(chg), 0);
    ctrl = {6'd63, 5'd9};
    @(negedge clk);
    check(!chg, "R8", "fine-only change not flagged", int'(chg), 0);
  endtask

  task automatic t_rerun_ignore();
    thr = 0; settle = 8'd6;
    clear_mon();
    pulse_start();
    check(!done, "R9", "done clears after start", int'(done), 1'b0);
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    wait_done("R9");
    check(windows == 1, "R9", "start during search ignored", windows, 1);
    check(cal_x == 0, "R5", "lead at fine 0", int'(cal_x), 0);
  endtask

  task automatic t_error();
    thr = 32; settle = 8'd0;
    clear_mon();
    pulse_start();
    wait_done("R6");
    check(err, "R6", "error when never leads", int'(err), 1);
    check(cal_x == 31, "R6", "offset at full scale", int'(cal_x), 31);
    check(windows == 32, "R6", "all fine values tried", windows, 32);
    check(last_len == 3, "R4", "zero settle acts as one", last_len, 3);
    thr = 7; settle = 8'd2;
    clear_mon();
    pulse_start();
    wait_done("R6");
    check(cal_x == 7, "R5", "later search offset", int'(cal_x), 7);
    check(err, "R6", "error stays set", int'(err), 1);
    check(last_len == 4, "R4", "two-cycle settle window", last_len, 4);
    rst_n = 1'b0;
    @(negedge clk);
    check(!err, "R1", "reset clears error", int'(err), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_mid_search();
    t_normal();
    t_rerun_ignore();
    t_error();
    repeat (2) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule